// File: doc/BRIEF.md
# Prefetch Issue Controller

This block keeps a short ordered table of pending prefetch candidates. Every candidate holds an address and an access kind: read, or any non-read access. In each cycle the controller sends as many of the oldest candidates as it can to the lower memory system. The limit is the number of memory ports that are free in that cycle. Nothing is sent while the first-level data queue reports full. Each request carries its address, the cache level it targets and an exclusive flag.

A separate check decides whether an incoming memory operation may enter the table. The operation must have its address resolved and must be cacheable. It must not have been prefetched before. The table must have room, and prefetching must be switched on. A configured default level of zero switches prefetching off. A second configuration bit can send every non-read prefetch to the second cache level instead of the default level.

Top module: `pfi_issue_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the table count is 0 and `req_valid` is all zeros, whatever the number of free ports.
- R2: `cand_accept` is 1 only when all of these hold: `cand_valid` is 1, `cfg_dflt_lvl` is nonzero, the table count is below DEPTH, `cand_addr_rdy` is 1, `cand_uncached` is 0 and `cand_prefetched` is 0. Otherwise it is 0 and the table count is unchanged by that candidate.
- R3: When `cfg_dflt_lvl` is 0, no candidate is accepted.
- R4: At most one candidate is accepted per cycle. It is appended behind the entries that remain, and it can first be issued in the following cycle.
- R5: The number of requests in a cycle is the smaller of the table count and `free_ports`, and 0 while `l1q_full` is 1. The valid requests occupy the low slots of `req_valid` without gaps.
- R6: Request slot k carries the k-th oldest table entry. Slot k occupies bits [k*AW +: AW] of `req_addr`, bits [k*LVL_W +: LVL_W] of `req_lvl` and bit k of `req_excl`.
- R7: `req_excl` is 1 for a non-read candidate (`cand_write` = 1) and 0 for a read.
- R8: `req_lvl` equals `cfg_dflt_lvl`, except that it is 2 for a non-read candidate while `cfg_wr_l2` is 1. The level applied is the configuration in force in the cycle of issue.
- R9: Issued entries leave the table and are never issued again. The remaining entries close up in their original order. The next count is the count, minus the number issued, plus one if a candidate was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dflt_lvl | input | LVL_W | Default target level; 0 disables prefetching |
| cfg_wr_l2 | input | 1 | Send non-read prefetches to level 2 |
| free_ports | input | PORT_W | Memory ports free this cycle |
| l1q_full | input | 1 | First-level data queue is full |
| cand_valid | input | 1 | A candidate memory op is presented |
| cand_addr | input | AW | Candidate address |
| cand_write | input | 1 | Candidate is a non-read access |
| cand_addr_rdy | input | 1 | Candidate address is resolved |
| cand_uncached | input | 1 | Candidate is an uncached access |
| cand_prefetched | input | 1 | Candidate was prefetched before |
| cand_accept | output | 1 | Candidate enters the table at the next edge |
| req_valid | output | DEPTH | Per-slot prefetch request valid |
| req_addr | output | DEPTH*AW | Per-slot request address |
| req_lvl | output | DEPTH*LVL_W | Per-slot target level |
| req_excl | output | DEPTH | Per-slot exclusive flag |
| tbl_count | output | CW | Number of entries in the table |

## Verification
The hardest case to reach is a cycle that issues several entries and appends a new one at the same time. The append position then depends on the count after removal, not the count before it. The vector table builds up a full table while no ports are free. It then confirms that a full table refuses a new candidate. Next it releases ports in steps of one and two while candidates keep arriving, and it checks the slot addresses in the following cycle so that the compaction order is visible. Directed tests change the level configuration between insertion and issue, and they apply reset while entries are pending.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
   // Level used for redirected non-read prefetches
   localparam int unsigned LVL_L2 = 2;

   // Requests allowed this cycle: bounded by occupancy and ports, zero when stalled
   function automatic int unsigned issue_count(int unsigned occ, int unsigned ports,
                                               logic q_full);
      if (q_full) return 0;
      return (ports < occ) ? ports : occ;
   endfunction
endpackage

// File: rtl/pfi_qualify.sv
module pfi_qualify #(
   parameter int DEPTH = 4,
   parameter int LVL_W = 2,
   parameter int CW    = 3
) (
   input  logic             cand_valid,
   input  logic             cand_addr_rdy,
   input  logic             cand_uncached,
   input  logic             cand_prefetched,
   input  logic [LVL_W-1:0] cfg_dflt_lvl,
   input  logic [CW-1:0]    count,
   output logic             accept
);
   logic pf_enabled;
   logic has_room;

   assign pf_enabled = |cfg_dflt_lvl;
   assign has_room   = count < CW'(DEPTH);
   assign accept     = cand_valid & pf_enabled & has_room & cand_addr_rdy
                       & ~cand_uncached & ~cand_prefetched;
endmodule

// File: rtl/pfi_table.sv
module pfi_table #(
   parameter int DEPTH = 4,
   parameter int AW    = 32,
   parameter int CW    = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CW-1:0]               n_iss,
   input  logic                        ins,
   input  logic [AW-1:0]               ins_addr,
   input  logic                        ins_wr,
   output logic [DEPTH-1:0][AW-1:0]    ent_addr,
   output logic [DEPTH-1:0]            ent_wr,
   output logic [CW-1:0]               count
);
   logic [CW-1:0] remain;

   assign remain = count - n_iss;

   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= remain + CW'(ins);
   end

   // Each entry takes the survivor n_iss places above it, or the new candidate
   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [AW-1:0] nxt_addr;
      logic          nxt_wr;
      always_comb begin
         nxt_addr = ent_addr[g];
         nxt_wr   = ent_wr[g];
         for (int s = g; s < DEPTH; s++) begin
            if (CW'(s - g) == n_iss) begin
               nxt_addr = ent_addr[s];
               nxt_wr   = ent_wr[s];
            end
         end
         if (ins && (CW'(g) == remain)) begin
            nxt_addr = ins_addr;
            nxt_wr   = ins_wr;
         end
      end
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_addr[g] <= '0;
            ent_wr[g]   <= 1'b0;
         end else begin
            ent_addr[g] <= nxt_addr;
            ent_wr[g]   <= nxt_wr;
         end
      end
   end
endmodule

// File: rtl/pfi_issue.sv
module pfi_issue
   import pfi_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int AW     = 32,
   parameter int LVL_W  = 2,
   parameter int PORT_W = 3,
   parameter int CW     = 3
) (
   input  logic [CW-1:0]              count,
   input  logic [PORT_W-1:0]          free_ports,
   input  logic                       l1q_full,
   input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
   input  logic [DEPTH-1:0]           ent_wr,
   input  logic [LVL_W-1:0]           cfg_dflt_lvl,
   input  logic                       cfg_wr_l2,
   output logic [CW-1:0]              n_iss,
   output logic [DEPTH-1:0]           req_valid,
   output logic [DEPTH*AW-1:0]        req_addr,
   output logic [DEPTH*LVL_W-1:0]     req_lvl,
   output logic [DEPTH-1:0]           req_excl
);
   assign n_iss = CW'(issue_count(32'(count), 32'(free_ports), l1q_full));

   for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      assign req_valid[k]             = CW'(k) < n_iss;
      assign req_addr[k*AW +: AW]     = ent_addr[k];
      assign req_excl[k]              = ent_wr[k];
      assign req_lvl[k*LVL_W +: LVL_W] = (ent_wr[k] && cfg_wr_l2) ? LVL_W'(LVL_L2)
                                                                 : cfg_dflt_lvl;
   end
endmodule

// File: rtl/pfi_issue_ctrl.sv
module pfi_issue_ctrl #(
   parameter  int DEPTH  = 4,
   parameter  int AW     = 32,
   parameter  int LVL_W  = 2,
   parameter  int PORT_W = 3,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LVL_W-1:0]        cfg_dflt_lvl,
   input  logic                    cfg_wr_l2,
   input  logic [PORT_W-1:0]       free_ports,
   input  logic                    l1q_full,
   input  logic                    cand_valid,
   input  logic [AW-1:0]           cand_addr,
   input  logic                    cand_write,
   input  logic                    cand_addr_rdy,
   input  logic                    cand_uncached,
   input  logic                    cand_prefetched,
   output logic                    cand_accept,
   output logic [DEPTH-1:0]        req_valid,
   output logic [DEPTH*AW-1:0]     req_addr,
   output logic [DEPTH*LVL_W-1:0]  req_lvl,
   output logic [DEPTH-1:0]        req_excl,
   output logic [CW-1:0]           tbl_count
);
   // Elaboration-time parameter checks
   if (DEPTH < 1)  begin : g_bad_depth $error("DEPTH must be at least 1"); end
   if (LVL_W < 2)  begin : g_bad_lvl   $error("LVL_W must hold level 2"); end
   if (PORT_W < 1) begin : g_bad_port  $error("PORT_W must be at least 1"); end

   logic [DEPTH-1:0][AW-1:0] ent_addr;
   logic [DEPTH-1:0]         ent_wr;
   logic [CW-1:0]            n_iss;

   pfi_qualify #(.DEPTH(DEPTH), .LVL_W(LVL_W), .CW(CW)) u_qual (
      .cand_valid     (cand_valid),
      .cand_addr_rdy  (cand_addr_rdy),
      .cand_uncached  (cand_uncached),
      .cand_prefetched(cand_prefetched),
      .cfg_dflt_lvl   (cfg_dflt_lvl),
      .count          (tbl_count),
      .accept         (cand_accept)
   );

   pfi_table #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_tbl (
      .clk     (clk),
      .rst_n   (rst_n),
      .n_iss   (n_iss),
      .ins     (cand_accept),
      .ins_addr(cand_addr),
      .ins_wr  (cand_write),
      .ent_addr(ent_addr),
      .ent_wr  (ent_wr),
      .count   (tbl_count)
   );

   pfi_issue #(.DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W), .PORT_W(PORT_W), .CW(CW)) u_iss (
      .count       (tbl_count),
      .free_ports  (free_ports),
      .l1q_full    (l1q_full),
      .ent_addr    (ent_addr),
      .ent_wr      (ent_wr),
      .cfg_dflt_lvl(cfg_dflt_lvl),
      .cfg_wr_l2   (cfg_wr_l2),
      .n_iss       (n_iss),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_lvl     (req_lvl),
      .req_excl    (req_excl)
   );
endmodule

// File: rtl/pfi_issue_ctrl_chk.sv
module pfi_issue_ctrl_chk #(
   parameter int DEPTH  = 4,
   parameter int AW     = 32,
   parameter int LVL_W  = 2,
   parameter int PORT_W = 3,
   parameter int CW     = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [LVL_W-1:0]        cfg_dflt_lvl,
   input logic                    cfg_wr_l2,
   input logic [PORT_W-1:0]       free_ports,
   input logic                    l1q_full,
   input logic                    cand_valid,
   input logic                    cand_addr_rdy,
   input logic                    cand_uncached,
   input logic                    cand_prefetched,
   input logic                    cand_accept,
   input logic [DEPTH-1:0]        req_valid,
   input logic [DEPTH*LVL_W-1:0]  req_lvl,
   input logic [DEPTH-1:0]        req_excl,
   input logic [CW-1:0]           tbl_count
);
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tbl_count) <= DEPTH);

   p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (32'(tbl_count) == 32'($past(tbl_count)) - $countones($past(req_valid))
                                  + 32'($past(cand_accept))));

   p_accept_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cand_accept |-> (cand_valid && cand_addr_rdy && !cand_uncached && !cand_prefetched
                       && (32'(tbl_count) < DEPTH)));

   p_off_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dflt_lvl == '0) |-> !cand_accept);

   p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      l1q_full |-> (req_valid == '0));

   p_port_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_valid) <= 32'(free_ports));

   p_occ_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_valid) <= 32'(tbl_count));

   p_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_valid + 1'b1) & req_valid) == '0);

   p_read_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[0] && !req_excl[0]) |-> (req_lvl[LVL_W-1:0] == cfg_dflt_lvl));
endmodule

bind pfi_issue_ctrl pfi_issue_ctrl_chk #(
   .DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W), .PORT_W(PORT_W), .CW(CW)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_dflt_lvl   (cfg_dflt_lvl),
   .cfg_wr_l2      (cfg_wr_l2),
   .free_ports     (free_ports),
   .l1q_full       (l1q_full),
   .cand_valid     (cand_valid),
   .cand_addr_rdy  (cand_addr_rdy),
   .cand_uncached  (cand_uncached),
   .cand_prefetched(cand_prefetched),
   .cand_accept    (cand_accept),
   .req_valid      (req_valid),
   .req_lvl        (req_lvl),
   .req_excl       (req_excl),
   .tbl_count      (tbl_count)
);

// File: tb/tb_pfi_issue_ctrl.sv
`timescale 1ns/1ps
module tb_pfi_issue_ctrl;
   localparam int DEPTH = 4, AW = 32, LVL_W = 2, PORT_W = 3, CW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LVL_W-1:0] cfg_dflt_lvl = 2'd1;
   logic cfg_wr_l2 = 1'b1;
   logic [PORT_W-1:0] free_ports = '0;
   logic l1q_full = 1'b0;
   logic cand_valid = 1'b0, cand_write = 1'b0, cand_addr_rdy = 1'b0;
   logic cand_uncached = 1'b0, cand_prefetched = 1'b0;
   logic [AW-1:0] cand_addr = '0;
   logic cand_accept;
   logic [DEPTH-1:0] req_valid, req_excl;
   logic [DEPTH*AW-1:0] req_addr;
   logic [DEPTH*LVL_W-1:0] req_lvl;
   logic [CW-1:0] tbl_count;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pfi_issue_ctrl #(.DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W), .PORT_W(PORT_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_dflt_lvl(cfg_dflt_lvl), .cfg_wr_l2(cfg_wr_l2),
      .free_ports(free_ports), .l1q_full(l1q_full), .cand_valid(cand_valid),
      .cand_addr(cand_addr), .cand_write(cand_write), .cand_addr_rdy(cand_addr_rdy),
      .cand_uncached(cand_uncached), .cand_prefetched(cand_prefetched),
      .cand_accept(cand_accept), .req_valid(req_valid), .req_addr(req_addr),
      .req_lvl(req_lvl), .req_excl(req_excl), .tbl_count(tbl_count));

   typedef struct packed {
      logic       cv;
      logic [7:0] a;
      logic       wr, rdy, unc, pf;
      logic [2:0] ports;
      logic       full;
      logic       e_acc;
      logic [3:0] e_mask;
      logic [2:0] e_cnt;
      logic [7:0] e_a0;
      logic [1:0] e_l0;
      logic       e_x0;
      logic [7:0] e_a1;
   } vec_t;

   // dflt level 1, non-read to level 2 enabled for the whole walk
   localparam vec_t VEC [16] = '{
      '{1'b1, 8'h10, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 4'b0000, 3'd0, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b1, 8'h20, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 4'b0000, 3'd1, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b1, 8'h30, 1'b0, 1'b1, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0000, 3'd2, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b1, 8'h34, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0000, 3'd2, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b1, 8'h38, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0, 4'b0000, 3'd2, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b1, 8'h40, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 4'b0000, 3'd2, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b1, 8'h50, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b1, 4'b0000, 3'd3, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b1, 8'h60, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0000, 3'd4, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b1, 1'b0, 4'b0000, 3'd4, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'b0001, 3'd4, 8'h10, 2'd1, 1'b0, 8'h00},
      '{1'b1, 8'h70, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 1'b1, 4'b0011, 3'd3, 8'h20, 2'd2, 1'b1, 8'h40},
      '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 1'b0, 4'b0011, 3'd2, 8'h50, 2'd1, 1'b0, 8'h70},
      '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0, 1'b0, 4'b0000, 3'd0, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b1, 8'h80, 1'b1, 1'b1, 1'b0, 1'b0, 3'd3, 1'b0, 1'b1, 4'b0000, 3'd0, 8'h00, 2'd0, 1'b0, 8'h00},
      '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 1'b0, 4'b0001, 3'd1, 8'h80, 2'd2, 1'b1, 8'h00},
      '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 4'b0000, 3'd0, 8'h00, 2'd0, 1'b0, 8'h00}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic cv, input logic [7:0] a, input logic wr, input logic rdy,
                        input logic unc, input logic pf, input logic [2:0] ports,
                        input logic full);
      @(negedge clk);
      cand_valid = cv; cand_addr = {24'h0, a}; cand_write = wr; cand_addr_rdy = rdy;
      cand_uncached = unc; cand_prefetched = pf; free_ports = ports; l1q_full = full;
      #2;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset state, with ports offered and a valid candidate present
      drive(1'b1, 8'hEE, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0);
      repeat (2) @(posedge clk);
      #1;
      check("R1 count in reset", 64'(tbl_count), 0);
      check("R1 req_valid in reset", 64'(req_valid), 0);
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0);
      rst_n = 1'b1;
      check("R1 count after reset", 64'(tbl_count), 0);
      check("R1 req_valid after reset", 64'(req_valid), 0);

      // Vector walk: R2 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < 16; i++) begin
         drive(VEC[i].cv, VEC[i].a, VEC[i].wr, VEC[i].rdy, VEC[i].unc, VEC[i].pf,
               VEC[i].ports, VEC[i].full);
         check($sformatf("R2 accept v%0d", i), 64'(cand_accept), 64'(VEC[i].e_acc));
         check($sformatf("R5 req_valid v%0d", i), 64'(req_valid), 64'(VEC[i].e_mask));
         check($sformatf("R9 count v%0d", i), 64'(tbl_count), 64'(VEC[i].e_cnt));
         if (VEC[i].e_mask[0]) begin
            check($sformatf("R6 slot0 addr v%0d", i), 64'(req_addr[AW-1:0]), 64'(VEC[i].e_a0));
            check($sformatf("R8 slot0 level v%0d", i), 64'(req_lvl[LVL_W-1:0]), 64'(VEC[i].e_l0));
            check($sformatf("R7 slot0 excl v%0d", i), 64'(req_excl[0]), 64'(VEC[i].e_x0));
         end
         if (VEC[i].e_mask[1])
            check($sformatf("R6 slot1 addr v%0d", i), 64'(req_addr[2*AW-1:AW]), 64'(VEC[i].e_a1));
      end

      // R3: level 0 disables acceptance
      cfg_dflt_lvl = 2'd0;
      drive(1'b1, 8'h88, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
      check("R3 accept when disabled", 64'(cand_accept), 0);
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0);
      check("R3 table stays empty", 64'(tbl_count), 0);
      check("R3 no request", 64'(req_valid), 0);

      // R8 R7: level 3, no redirect; level taken at issue time
      cfg_dflt_lvl = 2'd2;
      drive(1'b1, 8'h90, 1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
      drive(1'b1, 8'hA0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
      cfg_dflt_lvl = 2'd3;
      cfg_wr_l2 = 1'b0;
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0);
      check("R5 two issued", 64'(req_valid), 64'h3);
      check("R6 slot0 addr", 64'(req_addr[AW-1:0]), 64'h90);
      check("R8 write at default level", 64'(req_lvl[LVL_W-1:0]), 3);
      check("R7 write exclusive", 64'(req_excl[0]), 1);
      check("R6 slot1 addr", 64'(req_addr[2*AW-1:AW]), 64'hA0);
      check("R8 read at default level", 64'(req_lvl[2*LVL_W-1:LVL_W]), 3);
      check("R7 read shared", 64'(req_excl[1]), 0);
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0);
      check("R9 issued entries gone", 64'(tbl_count), 0);
      check("R9 no reissue", 64'(req_valid), 0);

      // R1: reset with a pending entry
      drive(1'b1, 8'hB0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
      check("R4 entry present before reset", 64'(tbl_count), 1);
      rst_n = 1'b0;
      @(posedge clk);
      drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0);
      rst_n = 1'b1;
      check("R1 count cleared by reset", 64'(tbl_count), 0);
      check("R1 no request after reset", 64'(req_valid), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule